// File: doc/BRIEF.md
# Spare Lane Remapping Controller

This block sits between a wide vector datapath and its physical functional units. It places `LANES` logical lanes onto `LANES + SPARES` physical units, some of which a test step has marked as too slow to use. A fault mask loaded once at test time selects which physical units are healthy. From that mask the block builds a crossbar configuration in which every logical lane has exactly one active crossing. Through this crossbar each lane's operand goes to a healthy unit, and each unit's result comes back to the lane that owns it. Units that carry no lane are switched off through a per-unit power enable.

Two placement policies exist. In pooled mode the spares form one shared reserve. Logical lane i takes the i-th healthy unit in ascending index order, so lane order is kept and any spread of failures, adjacent ones included, is absorbed while enough units survive. In grouped mode each run of four main units owns one spare, located at index `LANES + group`. A faulty main unit is replaced by the spare of its group, and a group with two or more faults among its five units cannot be repaired. The mapping is built serially, one physical unit per clock, and a ready flag marks the moment the configuration becomes valid.

Top module: `lane_spare_remap`

## Requirements
- R1: After reset, `ready` and `unrepairable` are low, every `unit_pwr_en` bit is 0, and `lane_res` and `unit_op` are all zero.
- R2: A pulse on `mask_load` captures the mask, clears `ready` on the next clock, and raises `ready` exactly `PHYS + 1` clocks after the loading clock (one clock per physical unit, then one evaluation clock). While `ready` is low, `lane_res`, `unit_op` and `unit_pwr_en` are zero.
- R3: In pooled mode (`cluster_mode` = 0 at load), logical lane i is served by the i-th physical unit whose mask bit is 0, counting upward from index 0. `lane_res` lane i equals that unit's `unit_res`, and that unit's `unit_op` equals `lane_op` lane i. A mask bit of 1 marks a faulty unit.
- R4: In pooled mode, `unrepairable` rises (instead of `ready`) exactly when fewer than `LANES` mask bits are 0.
- R5: In grouped mode (`cluster_mode` = 1 at load), logical lane i is served by unit i if that unit is healthy, otherwise by spare unit `LANES + i/4`.
- R6: In grouped mode, `unrepairable` rises when any group g holds two or more faulty units among mains 4g to 4g+3 and spare `LANES + g`.
- R7: When `ready` is high, `unit_pwr_en` is 1 for exactly the `LANES` units that carry a lane and 0 for faulty and unused units. Unpowered units see a zero `unit_op`.
- R8: `mask_in` and `cluster_mode` have no effect while `mask_load` is low. A configured block keeps its mapping and outputs when these inputs change.
- R9: When `unrepairable` is high, `ready` stays low and all crossbar outputs and power enables are zero until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_load | input | 1 | Capture `mask_in` and `cluster_mode`, then start mapping |
| mask_in | input | PHYS | Fault mask, 1 = faulty unit |
| cluster_mode | input | 1 | 0 = pooled spares, 1 = one spare per group of four |
| lane_op | input | LANES*DW | Operands, one DW field per logical lane |
| unit_res | input | PHYS*DW | Results, one DW field per physical unit |
| unit_op | output | PHYS*DW | Operands routed to physical units |
| lane_res | output | LANES*DW | Results routed back to logical lanes |
| unit_pwr_en | output | PHYS | Power enable per physical unit |
| ready | output | 1 | Configuration valid |
| unrepairable | output | 1 | Mask cannot be repaired in the loaded mode |

## Verification
The bench runs every one of the 1024 fault masks of an 8+2 configuration in both modes. This covers the sparse, adjacent, all-spares-faulty and too-many-faults patterns. A design that counted healthy units off by one would report repairable masks as failures at exactly `LANES` healthy units, or the reverse. Grouped masks with a faulty spare plus a faulty main in the same group catch a design that ignores the spare's own health. Masks with healthy spares left over in pooled mode catch a design that powers or feeds unused units. Flipping the mask and mode inputs after each configuration, without a load, exposes a design that reads its inputs live instead of from the captured copy.

// File: rtl/lane_remap_pkg.sv
package lane_remap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_EVAL,
        ST_DONE,
        ST_FAIL
    } walk_state_e;

    typedef enum logic {
        MODE_POOLED  = 1'b0,
        MODE_GROUPED = 1'b1
    } remap_mode_e;

    localparam int GROUP_SIZE = 4;

    // two-bit fault counter that stops at two
    function automatic logic [1:0] sat_inc2(input logic [1:0] v);
        return (v == 2'd2) ? v : v + 2'd1;
    endfunction

endpackage

// File: rtl/lane_remap_walker.sv
module lane_remap_walker
    import lane_remap_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int SPARES = 2,
    localparam int PHYS  = LANES + SPARES,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [PHYS-1:0]             mask_in,
    input  logic                        mode_in,
    output logic [LANES-1:0][PHYS-1:0]  xbar_q,
    output logic [PHYS-1:0][LW-1:0]     inv_idx_q,
    output logic [PHYS-1:0]             inv_vld_q,
    output logic                        ready,
    output logic                        unrep
);
    localparam int PW   = $clog2(PHYS + 1);
    localparam int CW   = $clog2(LANES + 1);
    localparam int NGRP = LANES / GROUP_SIZE;
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;

    walk_state_e                state_q;
    remap_mode_e                mode_q;
    logic [PHYS-1:0]            fault_q;
    logic [PW-1:0]              pos_q;
    logic [CW-1:0]              cnt_q;
    logic [NGRP-1:0][1:0]       gfault_q;

    logic [PW-1:0]  spare_u;
    logic [GW-1:0]  grp_m;
    logic [GW-1:0]  grp_s;
    logic [LW-1:0]  lane_p;
    logic [LW-1:0]  lane_c;
    logic           pos_is_main;
    logic           pos_is_gspare;
    logic           grp_bad;
    logic           last_pos;

    always_comb begin
        spare_u       = PW'(LANES) + (pos_q >> 2);
        grp_m         = GW'(pos_q >> 2);
        grp_s         = GW'(pos_q - PW'(LANES));
        lane_p        = LW'(pos_q);
        lane_c        = LW'(cnt_q);
        pos_is_main   = pos_q < PW'(LANES);
        pos_is_gspare = !pos_is_main && (pos_q < PW'(LANES + NGRP));
        last_pos      = pos_q == PW'(PHYS - 1);
        grp_bad       = 1'b0;
        for (int g = 0; g < NGRP; g++) begin
            if (gfault_q[g] == 2'd2) grp_bad = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_POOLED;
            fault_q   <= '0;
            pos_q     <= '0;
            cnt_q     <= '0;
            gfault_q  <= '0;
            xbar_q    <= '0;
            inv_idx_q <= '0;
            inv_vld_q <= '0;
        end else if (load) begin
            state_q   <= ST_WALK;
            mode_q    <= remap_mode_e'(mode_in);
            fault_q   <= mask_in;
            pos_q     <= '0;
            cnt_q     <= '0;
            gfault_q  <= '0;
            xbar_q    <= '0;
            inv_idx_q <= '0;
            inv_vld_q <= '0;
        end else begin
            case (state_q)
                ST_WALK: begin
                    if (mode_q == MODE_POOLED) begin
                        if (!fault_q[pos_q] && cnt_q < CW'(LANES)) begin
                            xbar_q[lane_c][pos_q] <= 1'b1;
                            inv_idx_q[pos_q]      <= lane_c;
                            inv_vld_q[pos_q]      <= 1'b1;
                            cnt_q                 <= cnt_q + CW'(1);
                        end
                    end else if (pos_is_main) begin
                        if (!fault_q[pos_q]) begin
                            xbar_q[lane_p][pos_q] <= 1'b1;
                            inv_idx_q[pos_q]      <= lane_p;
                            inv_vld_q[pos_q]      <= 1'b1;
                        end else begin
                            gfault_q[grp_m]         <= sat_inc2(gfault_q[grp_m]);
                            xbar_q[lane_p][spare_u] <= 1'b1;
                            inv_idx_q[spare_u]      <= lane_p;
                            inv_vld_q[spare_u]      <= 1'b1;
                        end
                    end else if (pos_is_gspare && fault_q[pos_q]) begin
                        gfault_q[grp_s] <= sat_inc2(gfault_q[grp_s]);
                    end
                    pos_q <= pos_q + PW'(1);
                    if (last_pos) state_q <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (mode_q == MODE_POOLED)
                        state_q <= (cnt_q == CW'(LANES)) ? ST_DONE : ST_FAIL;
                    else
                        state_q <= grp_bad ? ST_FAIL : ST_DONE;
                end
                default: state_q <= state_q;
            endcase
        end
    end

    assign ready = state_q == ST_DONE;
    assign unrep = state_q == ST_FAIL;

endmodule

// File: rtl/lane_remap_xbar.sv
module lane_remap_xbar #(
    parameter int LANES  = 8,
    parameter int SPARES = 2,
    parameter int DW     = 8,
    localparam int PHYS  = LANES + SPARES,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                        en,
    input  logic [LANES-1:0][PHYS-1:0]  xbar,
    input  logic [PHYS-1:0][LW-1:0]     inv_idx,
    input  logic [PHYS-1:0]             inv_vld,
    input  logic [LANES-1:0][DW-1:0]    lane_op,
    input  logic [PHYS-1:0][DW-1:0]     unit_res,
    output logic [PHYS-1:0][DW-1:0]     unit_op,
    output logic [LANES-1:0][DW-1:0]    lane_res,
    output logic [PHYS-1:0]             pwr_en
);
    // operands outward through the inverse index
    for (genvar p = 0; p < PHYS; p++) begin : g_unit
        assign pwr_en[p]  = en & inv_vld[p];
        assign unit_op[p] = (en && inv_vld[p]) ? lane_op[inv_idx[p]] : '0;
    end

    // results inward through the one-hot crossing matrix
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [DW-1:0] acc;
        always_comb begin
            acc = '0;
            for (int p = 0; p < PHYS; p++) begin
                if (xbar[i][p]) acc = acc | unit_res[p];
            end
        end
        assign lane_res[i] = en ? acc : '0;
    end

endmodule

// File: rtl/lane_spare_remap.sv
module lane_spare_remap #(
    parameter int LANES  = 8,
    parameter int SPARES = 2,
    parameter int DW     = 8,
    localparam int PHYS  = LANES + SPARES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mask_load,
    input  logic [PHYS-1:0]       mask_in,
    input  logic                  cluster_mode,
    input  logic [LANES*DW-1:0]   lane_op,
    input  logic [PHYS*DW-1:0]    unit_res,
    output logic [PHYS*DW-1:0]    unit_op,
    output logic [LANES*DW-1:0]   lane_res,
    output logic [PHYS-1:0]       unit_pwr_en,
    output logic                  ready,
    output logic                  unrepairable
);
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES-1:0][PHYS-1:0]  xbar_cfg;
    logic [PHYS-1:0][LW-1:0]     inv_idx;
    logic [PHYS-1:0]             inv_vld;
    logic [LANES-1:0][DW-1:0]    lop_a;
    logic [PHYS-1:0][DW-1:0]     ures_a;
    logic [PHYS-1:0][DW-1:0]     uop_a;
    logic [LANES-1:0][DW-1:0]    lres_a;

    assign lop_a    = lane_op;
    assign ures_a   = unit_res;
    assign unit_op  = uop_a;
    assign lane_res = lres_a;

    lane_remap_walker #(.LANES(LANES), .SPARES(SPARES)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (mask_load),
        .mask_in   (mask_in),
        .mode_in   (cluster_mode),
        .xbar_q    (xbar_cfg),
        .inv_idx_q (inv_idx),
        .inv_vld_q (inv_vld),
        .ready     (ready),
        .unrep     (unrepairable)
    );

    lane_remap_xbar #(.LANES(LANES), .SPARES(SPARES), .DW(DW)) u_xbar (
        .en       (ready),
        .xbar     (xbar_cfg),
        .inv_idx  (inv_idx),
        .inv_vld  (inv_vld),
        .lane_op  (lop_a),
        .unit_res (ures_a),
        .unit_op  (uop_a),
        .lane_res (lres_a),
        .pwr_en   (unit_pwr_en)
    );

endmodule

// File: rtl/lane_spare_remap_chk.sv
module lane_spare_remap_chk #(
    parameter int LANES = 8,
    parameter int PHYS  = 10,
    parameter int DW    = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 mask_load,
    input logic [PHYS*DW-1:0]   unit_op,
    input logic [LANES*DW-1:0]  lane_res,
    input logic [PHYS-1:0]      unit_pwr_en,
    input logic                 ready,
    input logic                 unrepairable
);
    assert_load_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
        mask_load |=> !ready);

    assert_quiet_when_unready_R2: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (lane_res == '0 && unit_op == '0 && unit_pwr_en == '0));

    assert_lane_count_powered_R7: assert property (@(posedge clk) disable iff (rst)
        ready |-> $countones(unit_pwr_en) == LANES);

    assert_held_config_R8: assert property (@(posedge clk) disable iff (rst)
        (ready && !mask_load) |=> (ready && $stable(unit_pwr_en)));

    assert_no_ready_when_broken_R9: assert property (@(posedge clk) disable iff (rst)
        !(ready && unrepairable));

endmodule

bind lane_spare_remap lane_spare_remap_chk #(.LANES(LANES), .PHYS(PHYS), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mask_load    (mask_load),
    .unit_op      (unit_op),
    .lane_res     (lane_res),
    .unit_pwr_en  (unit_pwr_en),
    .ready        (ready),
    .unrepairable (unrepairable)
);

// File: tb/test_lane_spare_remap.sv
`timescale 1ns/1ps
module test_lane_spare_remap;
    localparam int LANES = 8;
    localparam int SPARES = 2;
    localparam int DW = 8;
    localparam int PHYS = LANES + SPARES;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mask_load = 1'b0;
    logic [PHYS-1:0] mask_in = '0;
    logic cluster_mode = 1'b0;
    logic [LANES*DW-1:0] lane_op = '0;
    logic [PHYS*DW-1:0] unit_res = '0;
    logic [PHYS*DW-1:0] unit_op;
    logic [LANES*DW-1:0] lane_res;
    logic [PHYS-1:0] unit_pwr_en;
    logic ready;
    logic unrepairable;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lane_spare_remap #(.LANES(LANES), .SPARES(SPARES), .DW(DW)) i_lane_spare_remap (
        .clk(clk), .rst(rst), .mask_load(mask_load), .mask_in(mask_in),
        .cluster_mode(cluster_mode), .lane_op(lane_op), .unit_res(unit_res),
        .unit_op(unit_op), .lane_res(lane_res), .unit_pwr_en(unit_pwr_en),
        .ready(ready), .unrepairable(unrepairable)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    int emap [LANES];
    bit eok;
    logic [PHYS-1:0] epwr;
    logic [LANES*DW-1:0] elres;
    logic [PHYS*DW-1:0] euop;

    task automatic expect_cfg(input logic [PHYS-1:0] m, input bit cm);
        eok = 1;
        if (!cm) begin
            int k = 0;
            for (int p = 0; p < PHYS; p++) begin
                if (!m[p] && k < LANES) begin
                    emap[k] = p;
                    k++;
                end
            end
            eok = (k == LANES);
        end else begin
            for (int g = 0; g < LANES / 4; g++) begin
                int f = 0;
                for (int j = 0; j < 4; j++) f += int'(m[4*g+j]);
                f += int'(m[LANES+g]);
                if (f > 1) eok = 0;
            end
            for (int i = 0; i < LANES; i++) emap[i] = m[i] ? LANES + i / 4 : i;
        end
        epwr = '0;
        elres = '0;
        euop = '0;
        if (eok) begin
            for (int i = 0; i < LANES; i++) begin
                epwr[emap[i]] = 1'b1;
                elres[i*DW +: DW] = unit_res[emap[i]*DW +: DW];
                euop[emap[i]*DW +: DW] = lane_op[i*DW +: DW];
            end
        end
    endtask

    task automatic check_outputs(input bit cm, input string tag);
        string rs = cm ? "R6" : "R4";
        string rd = cm ? "R5" : "R3";
        chk({ready, unrepairable} == {eok, !eok}, {rs, " status ", tag},
            128'({ready, unrepairable}), 128'({eok, !eok}));
        chk(unit_pwr_en == epwr, {"R7 power ", tag}, 128'(unit_pwr_en), 128'(epwr));
        if (eok) begin
            chk(lane_res == elres, {rd, " lane_res ", tag}, 128'(lane_res), 128'(elres));
            chk(unit_op == euop, {rd, " R7 unit_op ", tag}, 128'(unit_op), 128'(euop));
        end else begin
            chk(lane_res == '0 && unit_op == '0, {"R9 zero outputs ", tag},
                128'(lane_res), 128'(0));
        end
    endtask

    task automatic run_cfg(input logic [PHYS-1:0] m, input bit cm);
        logic [7:0] salt = m[7:0];
        for (int i = 0; i < LANES; i++) lane_op[i*DW +: DW] = 8'((i + 1) * 17) ^ salt;
        for (int p = 0; p < PHYS; p++) unit_res[p*DW +: DW] = 8'(8'h20 + p * 7) ^ ~salt;
        @(negedge clk);
        mask_load = 1'b1;
        mask_in = m;
        cluster_mode = cm;
        @(negedge clk);
        mask_load = 1'b0;
        mask_in = ~m;
        cluster_mode = !cm;
        chk(!ready && !unrepairable, "R2 cleared after load", 128'({ready, unrepairable}), 128'(0));
        repeat (PHYS) @(negedge clk);
        chk(!ready && lane_res == '0 && unit_op == '0 && unit_pwr_en == '0,
            "R2 quiet before last clock", 128'({ready, unit_pwr_en}), 128'(0));
        @(negedge clk);
        expect_cfg(m, cm);
        check_outputs(cm, "at ready");
        // inputs other than load are ignored once configured (R8)
        mask_in = m ^ {PHYS{1'b1}};
        cluster_mode = !cm;
        repeat (3) @(negedge clk);
        expect_cfg(m, cm);
        chk(ready == eok && unit_pwr_en == epwr, "R8 held after input change",
            128'({ready, unit_pwr_en}), 128'({eok, epwr}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!ready && !unrepairable && unit_pwr_en == '0 && lane_res == '0 && unit_op == '0,
            "R1 reset state", 128'({ready, unrepairable, unit_pwr_en}), 128'(0));
        for (int cm = 0; cm < 2; cm++) begin
            for (int m = 0; m < (1 << PHYS); m++) begin
                run_cfg(PHYS'(m), cm[0]);
            end
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule